// File: doc/BRIEF.md
# Banked GPIO Controller with Key-Guarded Pin Release

This block is a memory-mapped general-purpose I/O controller. Its pins are grouped into banks of 32 and there can be up to eight banks. A pin number maps to its bank by shifting it right by five bits, and the low five bits select the bit within that bank. For each bank, software can drive the output levels through write-one set and write-one clear registers, read the synchronized pad levels, and manage edge interrupts through a status register, a mask register and a mask-clear register.

Every pin has its own control word. The word selects the direction and the edge that raises an interrupt, and it also stores a debounce setting. Each bank has an enable register, and a pin only drives its pad while its enable bit is clear. This register is protected: a write to it takes effect only when it comes directly after a write of a 32-bit key to the unlock address. The block's interrupt output is high whenever some pin has a pending status bit that is not masked.

The bus is a single-cycle write port with a combinational read port. Writes take effect on the clock edge where `bus_wr_en` is high. `bus_rdata` always shows the register selected by `bus_addr`.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: After reset, all outputs are 0 and every control word reads 0x001 (input, no trigger, debounce 0). Every mask bit and every enable bit reads 1, `pin_oe` is all 0 and `irq` is 0.
- R2: In bank b, a write to offset 0x040+4b sets each output bit whose data bit is 1, and a write to 0x060+4b clears it. Bits written 0 keep their value. Offset 0x000+4b reads back the output levels, which drive `pin_out`.
- R3: Offset 0x020+4b reads the pad levels after a two-flop synchronizer. A change on `pin_in` shows there after the second clock edge, and not after the first.
- R4: The control word of pin p is at 0x100+4p and keeps write-data bits 8:0. Bit 0 is the direction (1 = input), bits 4:3 the trigger and bits 8:5 the debounce setting. `pin_oe[p]` is 1 only when bit 0 is 0 and the pin's enable bit is 0.
- R5: The trigger field codes are: 0 for no interrupt, 1 for a rising edge, 2 for a falling edge and 3 for both edges. A matching synchronized edge sets the pin's bit in the status register at 0x080+4b.
- R6: Writing 1 to a status bit clears it and writing 0 leaves it alone. If an edge event arrives in the same cycle as a clear, the bit stays set.
- R7: Writing 1 at 0x0A0+4b masks pins and writing 1 at 0x0C0+4b unmasks them. 0x0A0+4b reads the mask. `irq` is 1 exactly when some status bit is set while its mask bit is 0.
- R8: Writing the key 0x00A5A501 to 0x520 allows the very next write to change an enable register at 0x500+4b. Clearing a bit there enables the pin and setting it releases the pin.
- R9: An enable-register write that does not directly follow the key is ignored. Any other write after the key, or a wrong key value, re-locks the enable registers.
- R10: Reads of the set, clear, mask-clear and unlock addresses return 0. Reads and writes addressed to a bank at or above NUM_BANKS return 0 and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for this cycle |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 32*NUM_BANKS | Raw pad input levels |
| pin_out | output | 32*NUM_BANKS | Output levels |
| pin_oe | output | 32*NUM_BANKS | Pad drive enable per pin |
| irq | output | 1 | OR of pending, unmasked interrupt status |

## Verification
The bench builds the block with NUM_BANKS=2, which gives 64 pins. With two banks, the stride of the per-bank registers and the independence of the banks can be checked. Bank index 2 is then a decoded but absent bank, so the rule for out-of-range addresses can be tested. The checks cover the set/clear rule at `pin_out`, the synchronizer delay, each trigger code, and a clear that meets an edge in the same cycle. They also cover the three ways the unlock can fail: no key, the key consumed by an earlier write, and an unrelated write placed between the key and the enable write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int          BANK_PINS   = 32;
  localparam int          CTRL_W      = 9;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h001;
  localparam logic [31:0] UNLOCK_KEY  = 32'h00A5A501;
  localparam logic [11:0] CTRL_BASE   = 12'h100;
  localparam logic [11:0] EN_BASE     = 12'h500;
  localparam logic [11:0] UNLOCK_ADDR = 12'h520;

  // Register group selected by address bits 7:5 below 0x100
  typedef enum logic [2:0] {
    GRP_OUT  = 3'd0,
    GRP_IN   = 3'd1,
    GRP_SET  = 3'd2,
    GRP_CLR  = 3'd3,
    GRP_IST  = 3'd4,
    GRP_MSK  = 3'd5,
    GRP_UMSK = 3'd6,
    GRP_NONE = 3'd7
  } grp_e;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_BOTH = 2'd3
  } trig_e;

  function automatic logic trig_hit(logic [1:0] sel, logic rise, logic fall);
    case (trig_e'(sel))
      TRIG_RISE: return rise;
      TRIG_FALL: return fall;
      TRIG_BOTH: return rise | fall;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] drive_update(logic [31:0] cur, logic [31:0] set_m,
                                               logic [31:0] clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction

  // Write-one-to-clear with new events taking priority
  function automatic logic [31:0] w1c_update(logic [31:0] cur, logic [31:0] clr_m,
                                             logic [31:0] events);
    return (cur & ~clr_m) | events;
  endfunction
endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      prev <= '0;
    end else begin
      chain[0] <= raw;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/gpio_key_guard.sv
module gpio_key_guard #(
  parameter logic [31:0] KEY = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        unlock_sel,
  input  logic [31:0] wdata,
  output logic        armed,
  output logic        key_hit
);
  assign key_hit = wr_en & unlock_sel & (wdata == KEY);

  // Any write re-arms only if it is the key itself
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed <= 1'b0;
    else if (wr_en) armed <= key_hit;
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BANK_PINS-1:0]   rise,
  input  logic [BANK_PINS-1:0]   fall,
  input  logic [2*BANK_PINS-1:0] trig,
  input  logic                   clr_we,
  input  logic                   mask_we,
  input  logic                   unmask_we,
  input  logic [31:0]            wdata,
  output logic [BANK_PINS-1:0]   status,
  output logic [BANK_PINS-1:0]   mask,
  output logic                   evt_any
);
  logic [BANK_PINS-1:0] evt;

  always_comb begin
    for (int i = 0; i < BANK_PINS; i++) evt[i] = trig_hit(trig[2*i +: 2], rise[i], fall[i]);
  end
  assign evt_any = |evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '1;
    end else begin
      status <= w1c_update(status, clr_we ? wdata : '0, evt);
      if (mask_we)        mask <= mask | wdata;
      else if (unmask_we) mask <= mask & ~wdata;
    end
  end
endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int NPINS    = NUM_BANKS * BANK_PINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr_en,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam int PIN_IDX_W = $clog2(NPINS);

  // ---------------- address decode ----------------
  logic [2:0]  bsel;
  logic        bank_ok, in_grp, ctrl_sel, en_sel, unlock_sel;
  grp_e        grp;
  logic [11:0] ctrl_off;
  logic [9:0]  ctrl_idx;
  logic [PIN_IDX_W-1:0] cpin;

  assign bsel       = bus_addr[4:2];
  assign bank_ok    = 32'(bsel) < NUM_BANKS;
  assign grp        = grp_e'(bus_addr[7:5]);
  assign in_grp     = (bus_addr[11:8] == 4'h0) && (bus_addr[1:0] == 2'b00);
  assign ctrl_off   = bus_addr - CTRL_BASE;
  assign ctrl_idx   = ctrl_off[11:2];
  assign cpin       = ctrl_idx[PIN_IDX_W-1:0];
  assign ctrl_sel   = (bus_addr >= CTRL_BASE) && (bus_addr < EN_BASE) &&
                      (bus_addr[1:0] == 2'b00) && (32'(ctrl_idx) < NPINS);
  assign en_sel     = (bus_addr[11:5] == EN_BASE[11:5]) && (bus_addr[1:0] == 2'b00) && bank_ok;
  assign unlock_sel = (bus_addr == UNLOCK_ADDR);

  // Named write events (also observed by the checker)
  logic set_hit, clr_hit, ist_hit, msk_hit, unmask_hit, ctrl_hit, en_try;
  assign set_hit    = bus_wr_en & in_grp & bank_ok & (grp == GRP_SET);
  assign clr_hit    = bus_wr_en & in_grp & bank_ok & (grp == GRP_CLR);
  assign ist_hit    = bus_wr_en & in_grp & bank_ok & (grp == GRP_IST);
  assign msk_hit    = bus_wr_en & in_grp & bank_ok & (grp == GRP_MSK);
  assign unmask_hit = bus_wr_en & in_grp & bank_ok & (grp == GRP_UMSK);
  assign ctrl_hit   = bus_wr_en & ctrl_sel;
  assign en_try     = bus_wr_en & en_sel;

  // ---------------- key guard ----------------
  logic key_armed, key_hit;
  gpio_key_guard #(.KEY(UNLOCK_KEY)) u_guard (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .unlock_sel(unlock_sel),
    .wdata(bus_wdata), .armed(key_armed), .key_hit(key_hit)
  );

  // ---------------- input synchronizer ----------------
  logic [NPINS-1:0] lvl_v, rise_v, fall_v;
  gpio_sync_edge #(.W(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .level(lvl_v), .rise(rise_v), .fall(fall_v)
  );

  // ---------------- per-pin control ----------------
  logic [CTRL_W-1:0]  ctrl_q [NPINS];
  logic [2*NPINS-1:0] trig_v;
  logic [NPINS-1:0]   out_q, en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPINS; p++) ctrl_q[p] <= CTRL_RESET;
    end else if (ctrl_hit) begin
      ctrl_q[cpin] <= bus_wdata[CTRL_W-1:0];
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign trig_v[2*p +: 2] = ctrl_q[p][4:3];
    assign pin_oe[p]        = ~ctrl_q[p][0] & ~en_q[p];
  end

  // ---------------- per-bank state ----------------
  logic [NPINS-1:0]     istat_v, imask_v;
  logic [NUM_BANKS-1:0] evt_bank;
  logic                 evt_any;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic here;
    assign here = (32'(bsel) == b);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q[b*BANK_PINS +: BANK_PINS] <= '0;
        en_q[b*BANK_PINS +: BANK_PINS]  <= '1;
      end else begin
        out_q[b*BANK_PINS +: BANK_PINS] <= drive_update(out_q[b*BANK_PINS +: BANK_PINS],
                                             (set_hit && here) ? bus_wdata : '0,
                                             (clr_hit && here) ? bus_wdata : '0);
        if (en_try && here && key_armed) en_q[b*BANK_PINS +: BANK_PINS] <= bus_wdata;
      end
    end

    gpio_irq_bank u_irq (
      .clk(clk), .rst_n(rst_n),
      .rise(rise_v[b*BANK_PINS +: BANK_PINS]),
      .fall(fall_v[b*BANK_PINS +: BANK_PINS]),
      .trig(trig_v[2*b*BANK_PINS +: 2*BANK_PINS]),
      .clr_we(ist_hit && here), .mask_we(msk_hit && here), .unmask_we(unmask_hit && here),
      .wdata(bus_wdata),
      .status(istat_v[b*BANK_PINS +: BANK_PINS]),
      .mask(imask_v[b*BANK_PINS +: BANK_PINS]),
      .evt_any(evt_bank[b])
    );
  end

  assign evt_any = |evt_bank;
  assign pin_out = out_q;
  assign irq     = |(istat_v & ~imask_v);

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (32'(bsel) == b) begin
        if (in_grp) begin
          case (grp)
            GRP_OUT: bus_rdata = out_q[b*BANK_PINS +: BANK_PINS];
            GRP_IN:  bus_rdata = lvl_v[b*BANK_PINS +: BANK_PINS];
            GRP_IST: bus_rdata = istat_v[b*BANK_PINS +: BANK_PINS];
            GRP_MSK: bus_rdata = imask_v[b*BANK_PINS +: BANK_PINS];
            default: bus_rdata = '0;
          endcase
        end
        if (en_sel) bus_rdata = en_q[b*BANK_PINS +: BANK_PINS];
      end
    end
    if (ctrl_sel) bus_rdata = {{(32-CTRL_W){1'b0}}, ctrl_q[cpin]};
  end
endmodule

// File: rtl/gpio_banked_checker.sv
module gpio_banked_checker #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr_en,
  input logic             irq,
  input logic [NPINS-1:0] out_q,
  input logic [NPINS-1:0] en_q,
  input logic [NPINS-1:0] istat_v,
  input logic             key_armed,
  input logic             key_hit,
  input logic             set_hit,
  input logic             clr_hit,
  input logic             unmask_hit,
  input logic             evt_any
);
  AST_OUT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> $past(set_hit || clr_hit));  // R2

  AST_STATUS_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(istat_v & ~$past(istat_v))) |-> $past(evt_any));  // R5

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(evt_any) || $past(unmask_hit)));  // R7

  AST_ENABLE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q != $past(en_q)) |-> $past(key_armed));  // R8

  AST_KEY_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (key_armed && bus_wr_en && !key_hit) |=> !key_armed);  // R9
endmodule

bind gpio_banked_ctrl gpio_banked_checker #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .irq(irq),
  .out_q(out_q), .en_q(en_q), .istat_v(istat_v),
  .key_armed(key_armed), .key_hit(key_hit),
  .set_hit(set_hit), .clr_hit(clr_hit), .unmask_hit(unmask_hit), .evt_any(evt_any)
);

// File: tb/test_gpio_banked_ctrl.sv
module test_gpio_banked_ctrl;
  localparam int NB = 2;
  localparam int NP = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr_en = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  gpio_banked_ctrl #(.NUM_BANKS(NB)) i_gpio_banked_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        we;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  1'b0, 12'h000, 32'h0,        32'h0},         // R1 outputs low
    '{4'd1,  1'b0, 12'h100, 32'h0,        32'h1},         // R1 pin0 input
    '{4'd1,  1'b0, 12'h0A0, 32'h0,        32'hFFFFFFFF},  // R1 all masked
    '{4'd1,  1'b0, 12'h504, 32'h0,        32'hFFFFFFFF},  // R1 all released
    '{4'd2,  1'b1, 12'h040, 32'h000000F0, 32'h0},         // R2 set
    '{4'd2,  1'b0, 12'h000, 32'h0,        32'h000000F0},
    '{4'd2,  1'b1, 12'h060, 32'h00000030, 32'h0},         // R2 clear
    '{4'd2,  1'b0, 12'h000, 32'h0,        32'h000000C0},
    '{4'd10, 1'b1, 12'h044, 32'h80000001, 32'h0},         // R10 bank1 stride
    '{4'd10, 1'b0, 12'h004, 32'h0,        32'h80000001},
    '{4'd10, 1'b0, 12'h000, 32'h0,        32'h000000C0},
    '{4'd4,  1'b1, 12'h104, 32'hFFFFFFF9, 32'h0},         // R4 ctrl pin1
    '{4'd4,  1'b0, 12'h104, 32'h0,        32'h000001F9},
    '{4'd9,  1'b1, 12'h500, 32'h0,        32'h0},         // R9 no key
    '{4'd9,  1'b0, 12'h500, 32'h0,        32'hFFFFFFFF},
    '{4'd8,  1'b1, 12'h520, 32'h00A5A501, 32'h0},         // R8 key then write
    '{4'd8,  1'b1, 12'h500, 32'hFFFFFF00, 32'h0},
    '{4'd8,  1'b0, 12'h500, 32'h0,        32'hFFFFFF00},
    '{4'd9,  1'b1, 12'h500, 32'h0,        32'h0},         // R9 key consumed
    '{4'd9,  1'b1, 12'h520, 32'h00A5A501, 32'h0},         // R9 other write between
    '{4'd9,  1'b1, 12'h040, 32'h0,        32'h0},
    '{4'd9,  1'b1, 12'h500, 32'h0,        32'h0},
    '{4'd9,  1'b1, 12'h520, 32'h00A5A500, 32'h0},         // R9 wrong key
    '{4'd9,  1'b1, 12'h500, 32'h0,        32'h0},
    '{4'd9,  1'b0, 12'h500, 32'h0,        32'hFFFFFF00},
    '{4'd10, 1'b0, 12'h008, 32'h0,        32'h0},         // R10 absent bank
    '{4'd10, 1'b0, 12'h040, 32'h0,        32'h0}          // R10 set reads 0
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 pin_oe", 32'(pin_oe != '0), 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) bus_write(VECS[i].addr, VECS[i].data);
      else begin
        bus_read(VECS[i].addr, v);
        check($sformatf("R%0d vec %0d", VECS[i].req, i), v, VECS[i].exp);
      end
    end

    // R4 / R2: direction and enable reach the pads
    bus_write(12'h110, 32'h0);             // pin4 output
    #1;
    check("R4 oe pin4", {31'b0, pin_oe[4]}, 32'h1);
    check("R4 oe pin5", {31'b0, pin_oe[5]}, 32'h0);
    check("R2 pin_out bank0", pin_out[31:0], 32'h000000C0);
    bus_write(12'h1A0, 32'h0);             // pin40 output, bank1 released
    #1;
    check("R4 oe pin40 released", {31'b0, pin_oe[40]}, 32'h0);

    // R3: two-flop synchronizer
    @(negedge clk); pin_in[10] = 1'b1;
    @(posedge clk);
    bus_read(12'h020, v);
    check("R3 after one edge", v & 32'h400, 32'h0);
    bus_read(12'h020, v);
    check("R3 after two edges", v & 32'h400, 32'h400);

    // R5: trigger codes
    repeat (3) @(posedge clk);
    bus_read(12'h080, v);
    check("R5 trigger off", v, 32'h0);
    bus_write(12'h130, 32'h009);           // pin12 rising
    bus_write(12'h134, 32'h011);           // pin13 falling
    bus_write(12'h138, 32'h019);           // pin14 both
    @(negedge clk); pin_in[14:12] = 3'b111;
    repeat (4) @(posedge clk);
    bus_read(12'h080, v);
    check("R5 rising events", v, 32'h00005000);
    check("R7 masked irq low", {31'b0, irq}, 32'h0);
    bus_write(12'h080, 32'hFFFFFFFF);
    bus_read(12'h080, v);
    check("R6 write-one clear", v, 32'h0);
    @(negedge clk); pin_in[14:12] = 3'b000;
    repeat (4) @(posedge clk);
    bus_read(12'h080, v);
    check("R5 falling events", v, 32'h00006000);

    // R7: mask and unmask
    bus_write(12'h0C0, 32'h00002000);
    #1 check("R7 unmask raises irq", {31'b0, irq}, 32'h1);
    bus_read(12'h0A0, v);
    check("R7 mask readback", v, 32'hFFFFDFFF);
    bus_write(12'h0A0, 32'h00002000);
    #1 check("R7 mask lowers irq", {31'b0, irq}, 32'h0);
    bus_write(12'h0C0, 32'h00002000);
    bus_write(12'h080, 32'h00002000);
    #1 check("R7 cleared status irq", {31'b0, irq}, 32'h0);
    bus_read(12'h080, v);
    check("R6 zero bits kept", v, 32'h00004000);

    // R6: clear and new edge in the same cycle
    @(negedge clk); pin_in[12] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = 12'h080; bus_wdata = 32'h00001000;
    @(negedge clk);
    bus_wr_en = 1'b0;
    bus_read(12'h080, v);
    check("R6 set wins over clear", v, 32'h00005000);

    // R1: reset again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 pin_out after reset", pin_out[31:0], 32'h0);
    check("R1 oe after reset", 32'(pin_oe != '0), 32'h0);
    bus_read(12'h500, v);
    check("R1 enable after reset", v, 32'hFFFFFFFF);
    bus_read(12'h110, v);
    check("R1 ctrl after reset", v, 32'h1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule